// File: doc/BRIEF.md
# Ring-Buffer UART Register Block

This block gives a processor a small set of UART ports, each seen as four 32-bit registers on a simple register bus, with no serial line logic behind them. Each port keeps two ring buffers. The receive ring is filled one byte at a time by a far-side producer and drained by processor reads. The transmit ring is filled by processor writes and drained one byte at a time by a far-side consumer. Both rings use a read pointer and a write pointer that wrap at capacity plus one. One slot is always left unused, so that full and empty can be told apart from the two pointers alone.

Every port raises a pending flag when its receive ring stops being empty, or when its transmit ring becomes empty. All ports share one flags word. It holds one enable and one pending bit per port, and one interrupt output is the OR of enabled pending bits. Software acknowledges a port by touching that port's Status register. Bytes that reach a full receive ring are dropped and the event is remembered in a sticky overrun flag. Transmit writes are never stalled.

Register address: bits [3:2] select the register (0 RX data read, 1 TX data write, 2 Status, 3 Control). The bits above bit 3 select the port, so each port takes 16 bytes.

Top module: `uring_top`

## Requirements
- R1: After reset every ring is empty, `tx_avail` is 0, `irq_flags` and `irq` are 0, and each port's Status reads 0x0000_0004.
- R2: Bytes leave each ring in the order they entered. A TX write stores `bus_wdata[7:0]` and ignores the higher bits. `tx_data` shows the oldest TX byte whenever `tx_avail` is 1.
- R3: A ring holds at most CAP bytes. Status bit1 is 1 exactly when RX holds CAP bytes, and bit3 is 1 exactly when TX holds CAP bytes. Bit0 is RX non-empty and bit2 is TX empty.
- R4: A byte pushed into a full RX ring is discarded and the stored bytes are kept. Status bit5 (overrun) becomes 1 and stays 1 until it is cleared.
- R5: A TX write while TX is full completes without stall, and its byte is discarded. The CAP stored bytes still come out unchanged.
- R6: Reading RX data while RX is empty returns 0 and moves no pointer. Reading the write-only registers returns 0.
- R7: The pointers wrap modulo CAP+1. Order and content are kept across many wraps.
- R8: A rising edge of RX non-empty or of TX empty on port i sets pending bit i (`irq_flags[i]`) one cycle later. `irq` is 1 when some port has both its pending bit and its enable bit (`irq_flags[NP+i]`) set.
- R9: Any read or write at port i's Status offset clears pending bit i only. A new edge in the same cycle takes priority and keeps the bit set.
- R10: A Control write acts on its own port. Bit0 empties TX. Bit1 empties RX and clears the overrun flag. Bit4 is written into the port's enable, which Status bit4 reflects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | PB+4 | Byte address: port in upper bits, register in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_push | input | NP | Per-port strobe that offers a byte to RX |
| rx_data | input | NP*W | Per-port byte offered to RX |
| tx_pop | input | NP | Per-port strobe that takes the TX head byte |
| tx_data | output | NP*W | Per-port TX head byte |
| tx_avail | output | NP | Per-port TX non-empty |
| irq_flags | output | 2*NP | Enables in the upper half, pending bits in the lower half |
| irq | output | 1 | Any enabled pending bit |

## Verification
A pointer that slips by one shows up the next time a byte is read, as a repeated, skipped or stale value on `bus_rdata` or `tx_data`. It also makes Status bits 0 to 3 wrong in the same cycle. A full or empty test off by one slot shows when the ring is filled: the CAP-th push reports a wrong full bit, or the overrun flag sets a byte too early or too late. A stale edge register shows up as a pending bit that appears without a fresh edge, or fails to appear one cycle after one. The bench therefore fills rings to capacity, drives them past it, and makes them wrap several times.

// File: rtl/uring_pkg.sv
package uring_pkg;

  typedef enum logic [1:0] {
    REG_RXDATA = 2'd0,
    REG_TXDATA = 2'd1,
    REG_STATUS = 2'd2,
    REG_CTRL   = 2'd3
  } reg_sel_e;

  localparam int unsigned ST_RXVALID = 0;
  localparam int unsigned ST_RXFULL  = 1;
  localparam int unsigned ST_TXEMPTY = 2;
  localparam int unsigned ST_TXFULL  = 3;
  localparam int unsigned ST_IE      = 4;
  localparam int unsigned ST_OVRUN   = 5;

  localparam int unsigned CT_TXRST = 0;
  localparam int unsigned CT_RXRST = 1;
  localparam int unsigned CT_IE    = 4;

  // successor of a ring pointer over 'slots' positions
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned slots);
    return (p + 1 >= slots) ? 0 : p + 1;
  endfunction

  function automatic logic [31:0] pack_status(input logic rx_valid, input logic rx_full,
                                              input logic tx_empty, input logic tx_full,
                                              input logic ie, input logic ovr);
    logic [31:0] s;
    s = '0;
    s[ST_RXVALID] = rx_valid;
    s[ST_RXFULL]  = rx_full;
    s[ST_TXEMPTY] = tx_empty;
    s[ST_TXFULL]  = tx_full;
    s[ST_IE]      = ie;
    s[ST_OVRUN]   = ovr;
    return s;
  endfunction

endpackage

// File: rtl/uring_fifo.sv
module uring_fifo
  import uring_pkg::*;
#(
  parameter int CAP = 6,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int SLOTS = CAP + 1;
  localparam int PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [W-1:0]  mem [SLOTS];
  logic [PW-1:0] wptr, rptr, wnext, rnext;
  logic          do_push, do_pop;

  assign wnext   = PW'(ring_next(32'(wptr), SLOTS));
  assign rnext   = PW'(ring_next(32'(rptr), SLOTS));
  assign empty   = (rptr == wptr);
  assign full    = (rptr == wnext);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign drop    = push && full;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wnext;
      if (do_pop)  rptr <= rnext;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= din;
  end
endmodule

// File: rtl/uring_port.sv
module uring_port
  import uring_pkg::*;
#(
  parameter int CAP = 6,
  parameter int W   = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_rx,
  input  logic         wr_tx,
  input  logic [W-1:0] tx_din,
  input  logic         wr_ctrl,
  input  logic         ctrl_txrst,
  input  logic         ctrl_rxrst,
  input  logic         ie,
  input  logic         rx_push,
  input  logic [W-1:0] rx_din,
  input  logic         tx_pop,
  output logic [W-1:0] tx_dout,
  output logic [31:0]  rx_word,
  output logic [31:0]  status,
  output logic         rx_evt,
  output logic         tx_evt,
  output logic         rx_flush,
  output logic         tx_flush,
  output logic         rx_empty,
  output logic         rx_full,
  output logic         tx_empty,
  output logic         tx_full,
  output logic         ovr
);
  logic [W-1:0] rx_dout;
  logic         rx_drop, tx_drop_unused;
  logic         rx_ne_q, tx_e_q;

  assign rx_flush = wr_ctrl && ctrl_rxrst;
  assign tx_flush = wr_ctrl && ctrl_txrst;

  uring_fifo #(.CAP(CAP), .W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .din(rx_din), .pop(rd_rx),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full), .drop(rx_drop)
  );

  uring_fifo #(.CAP(CAP), .W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(wr_tx), .din(tx_din), .pop(tx_pop),
    .dout(tx_dout), .empty(tx_empty), .full(tx_full), .drop(tx_drop_unused)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr     <= 1'b0;
      rx_ne_q <= 1'b0;
      tx_e_q  <= 1'b1;
    end else begin
      if (rx_flush)     ovr <= 1'b0;
      else if (rx_drop) ovr <= 1'b1;
      rx_ne_q <= !rx_empty;
      tx_e_q  <= tx_empty;
    end
  end

  assign rx_evt  = !rx_empty && !rx_ne_q;
  assign tx_evt  = tx_empty && !tx_e_q;
  assign rx_word = rx_empty ? 32'd0 : 32'(rx_dout);
  assign status  = pack_status(!rx_empty, rx_full, tx_empty, tx_full, ie, ovr);
endmodule

// File: rtl/uring_top.sv
module uring_top
  import uring_pkg::*;
#(
  parameter int NP  = 4,
  parameter int CAP = 6,
  parameter int W   = 8,
  localparam int PB = (NP > 1) ? $clog2(NP) : 1,
  localparam int AW = PB + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NP-1:0]   rx_push,
  input  logic [NP*W-1:0] rx_data,
  input  logic [NP-1:0]   tx_pop,
  output logic [NP*W-1:0] tx_data,
  output logic [NP-1:0]   tx_avail,
  output logic [2*NP-1:0] irq_flags,
  output logic            irq
);
  logic [PB-1:0] port_f;
  reg_sel_e      reg_f;
  logic [NP-1:0] rd_rx_w, wr_tx_w, stat_hit_w, wr_ctrl_w;
  logic [NP-1:0] rx_evt_w, tx_evt_w, rx_flush_w, tx_flush_w;
  logic [NP-1:0] rx_empty_w, rx_full_w, tx_empty_w, tx_full_w, ovr_w;
  logic [NP-1:0] ie_q, pend_q;
  logic [31:0]   rx_word_w [NP];
  logic [31:0]   status_w  [NP];

  assign port_f = bus_addr[AW-1:4];
  assign reg_f  = reg_sel_e'(bus_addr[3:2]);

  for (genvar i = 0; i < NP; i++) begin : g_port
    logic hit;
    assign hit           = bus_valid && (port_f == PB'(i));
    assign rd_rx_w[i]    = hit && !bus_write && (reg_f == REG_RXDATA);
    assign wr_tx_w[i]    = hit && bus_write && (reg_f == REG_TXDATA);
    assign stat_hit_w[i] = hit && (reg_f == REG_STATUS);
    assign wr_ctrl_w[i]  = hit && bus_write && (reg_f == REG_CTRL);

    uring_port #(.CAP(CAP), .W(W)) u_port (
      .clk(clk), .rst_n(rst_n),
      .rd_rx(rd_rx_w[i]), .wr_tx(wr_tx_w[i]), .tx_din(bus_wdata[W-1:0]),
      .wr_ctrl(wr_ctrl_w[i]), .ctrl_txrst(bus_wdata[CT_TXRST]),
      .ctrl_rxrst(bus_wdata[CT_RXRST]), .ie(ie_q[i]),
      .rx_push(rx_push[i]), .rx_din(rx_data[i*W +: W]), .tx_pop(tx_pop[i]),
      .tx_dout(tx_data[i*W +: W]), .rx_word(rx_word_w[i]), .status(status_w[i]),
      .rx_evt(rx_evt_w[i]), .tx_evt(tx_evt_w[i]),
      .rx_flush(rx_flush_w[i]), .tx_flush(tx_flush_w[i]),
      .rx_empty(rx_empty_w[i]), .rx_full(rx_full_w[i]),
      .tx_empty(tx_empty_w[i]), .tx_full(tx_full_w[i]), .ovr(ovr_w[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ie_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        if (wr_ctrl_w[i]) ie_q[i] <= bus_wdata[CT_IE];
        if (rx_evt_w[i] || tx_evt_w[i]) pend_q[i] <= 1'b1;
        else if (stat_hit_w[i])         pend_q[i] <= 1'b0;
      end
    end

    assign tx_avail[i] = !tx_empty_w[i];
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NP; i++) begin
      if (bus_valid && !bus_write && (port_f == PB'(i))) begin
        case (reg_f)
          REG_RXDATA: bus_rdata = rx_word_w[i];
          REG_STATUS: bus_rdata = status_w[i];
          default:    bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_flags = {ie_q, pend_q};
  assign irq       = |(ie_q & pend_q);
endmodule

// File: rtl/uring_checker.sv
module uring_checker #(
  parameter int NP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NP-1:0]   rx_push,
  input logic [NP-1:0]   rd_rx,
  input logic [NP-1:0]   stat_hit,
  input logic [NP-1:0]   rx_flush,
  input logic [NP-1:0]   rx_evt,
  input logic [NP-1:0]   tx_evt,
  input logic [NP-1:0]   rx_empty,
  input logic [NP-1:0]   rx_full,
  input logic [NP-1:0]   tx_empty,
  input logic [NP-1:0]   tx_full,
  input logic [NP-1:0]   ovr,
  input logic [2*NP-1:0] irq_flags
);
  for (genvar i = 0; i < NP; i++) begin : g_chk
    a_r3_rx_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_full[i] && rx_empty[i]));
    a_r3_tx_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full[i] && tx_empty[i]));
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push[i] && rx_full[i] && !rd_rx[i] && !rx_flush[i]) |=> (rx_full[i] && ovr[i]));
    a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx[i] && rx_empty[i] && !rx_push[i] && !rx_flush[i]) |=> rx_empty[i]);
    a_r8_rx_edge: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt[i] |=> irq_flags[i]);
    a_r8_tx_edge: assert property (@(posedge clk) disable iff (!rst_n)
      tx_evt[i] |=> irq_flags[i]);
    a_r9_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_hit[i] && !rx_evt[i] && !tx_evt[i]) |=> !irq_flags[i]);
    a_r10_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush[i] |=> (rx_empty[i] && !ovr[i]));
  end
endmodule

bind uring_top uring_checker #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rd_rx(rd_rx_w),
  .stat_hit(stat_hit_w), .rx_flush(rx_flush_w), .rx_evt(rx_evt_w),
  .tx_evt(tx_evt_w), .rx_empty(rx_empty_w), .rx_full(rx_full_w),
  .tx_empty(tx_empty_w), .tx_full(tx_full_w), .ovr(ovr_w), .irq_flags(irq_flags)
);

// File: tb/uring_top_test.sv
module uring_top_test;
  localparam int NP = 4, CAP = 6, W = 8, AW = 6;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] rx_push = '0, tx_pop = '0, tx_avail;
  logic [NP*W-1:0] rx_data = '0, tx_data;
  logic [2*NP-1:0] irq_flags;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  uring_top #(.NP(NP), .CAP(CAP), .W(W)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(int p, int r, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = AW'((p << 4) | (r << 2)); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(int p, int r, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = AW'((p << 4) | (r << 2));
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic push_rx(int p, logic [7:0] b);
    @(negedge clk);
    rx_push[p] = 1; rx_data[p*W +: W] = b;
    @(negedge clk);
    rx_push[p] = 0;
  endtask

  task automatic pop_tx(int p, output logic [7:0] b, output logic av);
    @(negedge clk);
    b = tx_data[p*W +: W]; av = tx_avail[p];
    tx_pop[p] = 1;
    @(negedge clk);
    tx_pop[p] = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int p = 0; p < NP; p++) begin
      bus_rd(p, 2, d); chk("R1 status after reset", d, 32'h4);
    end
    chk("R1 irq_flags", 32'(irq_flags), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_avail", 32'(tx_avail), 0);
    bus_rd(0, 1, d); chk("R6 read of TX data offset", d, 0);
  endtask

  task automatic t_rx_order();
    logic [31:0] d;
    push_rx(1, 8'hA1); push_rx(1, 8'hB2); push_rx(1, 8'hC3);
    bus_rd(1, 2, d); chk("R3 status rx_valid", d, 32'h5);
    bus_rd(1, 0, d); chk("R2 rx first", d, 32'hA1);
    bus_rd(1, 0, d); chk("R2 rx second", d, 32'hB2);
    bus_rd(1, 0, d); chk("R2 rx third", d, 32'hC3);
  endtask

  task automatic t_tx_order();
    logic [7:0] b; logic av; logic [31:0] d;
    bus_rd(2, 2, d);
    bus_wr(2, 1, 32'h155); bus_wr(2, 1, 32'h266); bus_wr(2, 1, 32'h377);
    pop_tx(2, b, av); chk("R2 tx first", {24'd0, b}, 32'h55); chk("R2 tx avail", 32'(av), 1);
    pop_tx(2, b, av); chk("R2 tx second", {24'd0, b}, 32'h66);
    pop_tx(2, b, av); chk("R2 tx third", {24'd0, b}, 32'h77);
    repeat (2) @(negedge clk);
    chk("R2 tx drained", 32'(tx_avail[2]), 0);
    chk("R8 tx empty edge pends", 32'(irq_flags[2]), 1);
    bus_rd(2, 2, d);
    @(negedge clk);
    chk("R9 status read clears pend", 32'(irq_flags[2]), 0);
  endtask

  task automatic t_rx_overflow();
    logic [31:0] d;
    bus_wr(0, 3, 32'h2);
    for (int k = 0; k < CAP; k++) push_rx(0, 8'(8'h10 + k));
    bus_rd(0, 2, d); chk("R3 rx full at CAP", d, 32'h7);
    push_rx(0, 8'hEE);
    bus_rd(0, 2, d); chk("R4 overrun flag", d, 32'h27);
    for (int k = 0; k < CAP; k++) begin
      bus_rd(0, 0, d); chk("R4 stored bytes kept", d, 32'(8'h10 + k));
    end
    bus_rd(0, 0, d); chk("R4 dropped byte absent", d, 0);
    bus_rd(0, 2, d); chk("R4 overrun sticky", d, 32'h24);
    bus_wr(0, 3, 32'h2);
    bus_rd(0, 2, d); chk("R10 rx reset clears overrun", d, 32'h4);
  endtask

  task automatic t_tx_full();
    logic [7:0] b; logic av; logic [31:0] d;
    for (int k = 0; k < CAP + 1; k++) bus_wr(3, 1, 32'(k + 1));
    bus_rd(3, 2, d); chk("R3 tx full bit", d & 32'hF, 32'h8);
    for (int k = 0; k < CAP; k++) begin
      pop_tx(3, b, av); chk("R5 tx stored bytes kept", {24'd0, b}, 32'(k + 1));
    end
    @(negedge clk);
    chk("R5 extra byte discarded", 32'(tx_avail[3]), 0);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    bus_rd(0, 0, d); chk("R6 empty rx reads zero", d, 0);
    bus_rd(0, 0, d); chk("R6 empty rx again", d, 0);
    push_rx(0, 8'h3C);
    bus_rd(0, 0, d); chk("R6 pointers unmoved", d, 32'h3C);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    for (int k = 0; k < 20; k++) begin
      push_rx(1, 8'(3 * k)); push_rx(1, 8'(3 * k + 1));
      bus_rd(1, 0, d); chk("R7 wrap first", d, 32'(8'(3 * k)));
      bus_rd(1, 0, d); chk("R7 wrap second", d, 32'(8'(3 * k + 1)));
    end
  endtask

  task automatic t_irq();
    logic [31:0] d;
    for (int p = 0; p < NP; p++) bus_rd(p, 2, d);
    @(negedge clk);
    chk("R9 all pend cleared", 32'(irq_flags[NP-1:0]), 0);
    bus_wr(1, 3, 32'h10);
    bus_rd(1, 2, d); chk("R10 status ie bit", d, 32'h14);
    push_rx(3, 8'h01);
    @(negedge clk);
    chk("R8 pend without enable", 32'(irq_flags), 32'h28);
    chk("R8 irq needs enable", 32'(irq), 0);
    push_rx(1, 8'h02);
    @(negedge clk);
    chk("R8 rx edge pends port1", 32'(irq_flags), 32'h2A);
    chk("R8 irq asserted", 32'(irq), 1);
    bus_wr(1, 2, 32'h0);
    @(negedge clk);
    chk("R9 write access clears port1 only", 32'(irq_flags), 32'h28);
    chk("R9 irq drops", 32'(irq), 0);
    bus_wr(1, 3, 32'h0);
    chk("R10 enable cleared", 32'(irq_flags[NP+1]), 0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    bus_wr(2, 1, 32'hAB); bus_wr(2, 1, 32'hCD);
    chk("R10 tx before reset", 32'(tx_avail[2]), 1);
    bus_wr(2, 3, 32'h1);
    chk("R10 tx reset empties", 32'(tx_avail[2]), 0);
    bus_rd(2, 2, d); chk("R10 status after tx reset", d & 32'hF, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rx_order();
    t_tx_order();
    t_rx_overflow();
    t_tx_full();
    t_empty_read();
    t_wrap();
    t_irq();
    t_flush();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule